// File: doc/BRIEF.md
# Dual-Limit Memory Address Breakpoint Unit

This unit is a debug aid for a processor core with three separate address buses: one for program fetch, one for X-data and one for Y-data. On each instruction cycle it captures one of those buses into a 16-bit address latch. A control field picks the bus, or tells the latch to hold its value. Two comparators then test the captured address, each against its own 16-bit limit register. Each comparator has its own condition: equal, not equal, greater-or-equal or less-than. When the two results are ANDed, the pair of limits marks out an address window. When they are ORed, the pair acts as two independent watch points.

An external debug controller loads the two limits and the control word through a small register port. It also reads them back the same way. That port stands in for the controller that sits behind a JTAG link. The controller should load the limits before it turns on the enable bit. While the enable is off, the unit reports no comparator hit and no breakpoint request. The per-comparator results are visible as outputs. The combined request is registered, so a downstream halt sequencer sees it one clock after the address that caused it was captured.

Top module: `addr_bkpt_unit`

## Requirements
- R1: After synchronous reset, both limit registers, the control register, the address latch, `dbg_rdata`, `cmp_hit` and `bkpt_req` are all zero.
- R2: Control bits [1:0] select the source the latch captures on a clock edge where `cyc_en` is high. 01 selects `pab`, 10 selects `xab` and 11 selects `yab`. With 00 the latch keeps its value.
- R3: When `cyc_en` is low, the address latch keeps its value whatever the buses carry.
- R4: A write to debug register 0 (limit 0) or register 1 (limit 1) takes effect at the next clock edge. A read of either register returns its current value on `dbg_rdata` one clock after the read is issued.
- R5: Debug register 2 holds the control word and reads back as written, zero-extended. Its layout is: [1:0] bus select, [3:2] condition 0, [5:4] condition 1, [6] combine mode and [7] enable. Debug register 3 reads the current latched address.
- R6: Condition code 00 makes a comparator hit when the latched address equals its limit. Code 01 makes it hit when they differ.
- R7: Condition code 10 makes a comparator hit when the latched address is greater than or equal to its limit, and code 11 when it is below it. Both compare as unsigned numbers. `cmp_hit[i]` is comparator i's result.
- R8: With combine bit 1, a breakpoint is requested only when both comparators hit. With combine bit 0, one hit is enough.
- R9: While the enable bit is 0, `cmp_hit` is 00 and `bkpt_req` stays low, whatever the limits and address are.
- R10: `bkpt_req` is registered. It rises one clock after the capture that made the combined condition true, and it is never high unless a comparator hit in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle strobe; the latch may capture on edges where it is high |
| pab | input | 16 | Program address bus |
| xab | input | 16 | X-data address bus |
| yab | input | 16 | Y-data address bus |
| dbg_wr | input | 1 | Debug register write strobe |
| dbg_rd | input | 1 | Debug register read strobe |
| dbg_addr | input | 2 | Debug register index (0 limit 0, 1 limit 1, 2 control, 3 latch) |
| dbg_wdata | input | 16 | Debug write data |
| dbg_rdata | output | 16 | Debug read data, valid one clock after the read |
| cmp_hit | output | 2 | Per-comparator match results |
| bkpt_req | output | 1 | Registered combined breakpoint request |

## Verification
The bus-select test places a different value on each of the three buses, so that a capture from the wrong bus shows up as a wrong value. It also changes the buses while the select is 00 or the strobe is low, which catches a latch that fails to hold. Limit addresses are stepped across each edge of the window: one below the lower limit, exactly on it, just below the upper limit, exactly on it, and 0xFFFF. These steps tell apart the off-by-one errors between greater-or-equal and greater-than and between less-than and less-or-equal. They also catch a signed compare. The same addresses are run in AND and OR combine mode and with the enable cleared, which separates combining errors from gating errors. The check of `bkpt_req` both in the capture cycle and one cycle later confirms the added register stage.

// File: rtl/abk_pkg.sv
package abk_pkg;

    localparam int unsigned NUM_LIM = 2;
    localparam int unsigned NUM_REG = NUM_LIM + 2;
    localparam int unsigned REG_CTRL = NUM_LIM;
    localparam int unsigned REG_LATCH = NUM_LIM + 1;

    typedef enum logic [1:0] {
        BUS_NONE = 2'b00,
        BUS_PROG = 2'b01,
        BUS_XDAT = 2'b10,
        BUS_YDAT = 2'b11
    } bus_sel_e;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_NE = 2'b01,
        CMP_GE = 2'b10,
        CMP_LT = 2'b11
    } cond_e;

    typedef struct packed {
        logic     enable;
        logic     and_mode;
        cond_e    cond1;
        cond_e    cond0;
        bus_sel_e bus_sel;
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    function automatic logic cond_result(cond_e c, logic is_eq, logic is_lt);
        logic r;
        unique case (c)
            CMP_EQ: r = is_eq;
            CMP_NE: r = !is_eq;
            CMP_GE: r = !is_lt;
            CMP_LT: r = is_lt;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/abk_bus_latch.sv
module abk_bus_latch
    import abk_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_en,
    input  bus_sel_e      sel,
    input  logic [AW-1:0] pab,
    input  logic [AW-1:0] xab,
    input  logic [AW-1:0] yab,
    output logic [AW-1:0] lat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else if (cyc_en) begin
            unique case (sel)
                BUS_NONE: lat_q <= lat_q;
                BUS_PROG: lat_q <= pab;
                BUS_XDAT: lat_q <= xab;
                BUS_YDAT: lat_q <= yab;
            endcase
        end
    end

endmodule

// File: rtl/abk_cmp.sv
module abk_cmp
    import abk_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] limit,
    input  cond_e         cond,
    input  logic          en,
    output logic          hit
);

    logic is_eq;
    logic is_lt;

    always_comb begin
        is_eq = (addr == limit);
        is_lt = (addr < limit);
        hit   = en && cond_result(cond, is_eq, is_lt);
    end

endmodule

// File: rtl/abk_regs.sv
module abk_regs
    import abk_pkg::*;
#(
    parameter int unsigned AW  = 16,
    parameter int unsigned RAW = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic                       rd,
    input  logic [RAW-1:0]             addr,
    input  logic [AW-1:0]              wdata,
    input  logic [AW-1:0]              lat_val,
    output logic [NUM_LIM-1:0][AW-1:0] lim_q,
    output ctrl_t                      ctrl_q,
    output logic [AW-1:0]              rdata
);

    logic [AW-1:0] rd_mux;

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= '0;
            end else if (wr && (int'(addr) == g)) begin
                lim_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr && (int'(addr) == REG_CTRL)) begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rd_mux = '0;
        if (int'(addr) < NUM_LIM) begin
            rd_mux = lim_q[addr];
        end else if (int'(addr) == REG_CTRL) begin
            rd_mux[CTRL_W-1:0] = ctrl_q;
        end else if (int'(addr) == REG_LATCH) begin
            rd_mux = lat_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/addr_bkpt_unit.sv
module addr_bkpt_unit
    import abk_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned REG_AW = $clog2(NUM_REG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cyc_en,
    input  logic [ADDR_W-1:0]  pab,
    input  logic [ADDR_W-1:0]  xab,
    input  logic [ADDR_W-1:0]  yab,
    input  logic               dbg_wr,
    input  logic               dbg_rd,
    input  logic [REG_AW-1:0]  dbg_addr,
    input  logic [ADDR_W-1:0]  dbg_wdata,
    output logic [ADDR_W-1:0]  dbg_rdata,
    output logic [NUM_LIM-1:0] cmp_hit,
    output logic               bkpt_req
);

    logic [ADDR_W-1:0]              lat_q;
    logic [NUM_LIM-1:0][ADDR_W-1:0] lim_q;
    ctrl_t                          ctrl_q;
    cond_e                          cond_sel [NUM_LIM];
    logic                           req_d;

    abk_regs #(.AW(ADDR_W), .RAW(REG_AW)) regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (dbg_wr),
        .rd      (dbg_rd),
        .addr    (dbg_addr),
        .wdata   (dbg_wdata),
        .lat_val (lat_q),
        .lim_q   (lim_q),
        .ctrl_q  (ctrl_q),
        .rdata   (dbg_rdata)
    );

    abk_bus_latch #(.AW(ADDR_W)) latch_i (
        .clk    (clk),
        .rst    (rst),
        .cyc_en (cyc_en),
        .sel    (ctrl_q.bus_sel),
        .pab    (pab),
        .xab    (xab),
        .yab    (yab),
        .lat_q  (lat_q)
    );

    assign cond_sel[0] = ctrl_q.cond0;
    assign cond_sel[1] = ctrl_q.cond1;

    for (genvar g = 0; g < NUM_LIM; g++) begin : g_cmp
        abk_cmp #(.AW(ADDR_W)) cmp_i (
            .addr  (lat_q),
            .limit (lim_q[g]),
            .cond  (cond_sel[g]),
            .en    (ctrl_q.enable),
            .hit   (cmp_hit[g])
        );
    end

    always_comb begin
        req_d = ctrl_q.and_mode ? (&cmp_hit) : (|cmp_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bkpt_req <= 1'b0;
        end else begin
            bkpt_req <= ctrl_q.enable && req_d;
        end
    end

endmodule

// File: rtl/abk_checker.sv
module abk_checker
    import abk_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               cyc_en,
    input logic [AW-1:0]      pab,
    input logic [AW-1:0]      xab,
    input logic [AW-1:0]      yab,
    input logic [NUM_LIM-1:0] cmp_hit,
    input logic               bkpt_req,
    input logic [AW-1:0]      lat_q,
    input ctrl_t              ctrl_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (lat_q == '0 && !bkpt_req && ctrl_q == '0));

    p_capture_prog_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && ctrl_q.bus_sel == BUS_PROG) |=> (lat_q == $past(pab)));

    p_capture_xdat_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && ctrl_q.bus_sel == BUS_XDAT) |=> (lat_q == $past(xab)));

    p_capture_ydat_r2: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && ctrl_q.bus_sel == BUS_YDAT) |=> (lat_q == $past(yab)));

    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!cyc_en || ctrl_q.bus_sel == BUS_NONE) |=> $stable(lat_q));

    p_and_needs_both_r8: assert property (@(posedge clk) disable iff (rst)
        (bkpt_req && $past(ctrl_q.and_mode)) |-> $past(&cmp_hit));

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.enable |-> (cmp_hit == '0));

    p_req_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
        bkpt_req |-> $past(cmp_hit != '0));

endmodule

bind addr_bkpt_unit abk_checker #(.AW(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cyc_en   (cyc_en),
    .pab      (pab),
    .xab      (xab),
    .yab      (yab),
    .cmp_hit  (cmp_hit),
    .bkpt_req (bkpt_req),
    .lat_q    (lat_q),
    .ctrl_q   (ctrl_q)
);

// File: tb/addr_bkpt_unit_tb.sv
module addr_bkpt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_en = 1'b0;
    logic [15:0] pab = '0;
    logic [15:0] xab = '0;
    logic [15:0] yab = '0;
    logic        dbg_wr = 1'b0;
    logic        dbg_rd = 1'b0;
    logic [1:0]  dbg_addr = '0;
    logic [15:0] dbg_wdata = '0;
    logic [15:0] dbg_rdata;
    logic [1:0]  cmp_hit;
    logic        bkpt_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    addr_bkpt_unit dut_i (
        .clk       (clk),
        .rst       (rst),
        .cyc_en    (cyc_en),
        .pab       (pab),
        .xab       (xab),
        .yab       (yab),
        .dbg_wr    (dbg_wr),
        .dbg_rd    (dbg_rd),
        .dbg_addr  (dbg_addr),
        .dbg_wdata (dbg_wdata),
        .dbg_rdata (dbg_rdata),
        .cmp_hit   (cmp_hit),
        .bkpt_req  (bkpt_req)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // ctrl layout: [7] enable, [6] and, [5:4] cond1, [3:2] cond0, [1:0] bus select
    function automatic logic [15:0] ctl(logic [1:0] sel, logic [1:0] c0, logic [1:0] c1,
                                        logic andm, logic en);
        return {8'h00, en, andm, c1, c0, sel};
    endfunction

    task automatic wr_reg(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        dbg_wr = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(negedge clk);
        dbg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        dbg_rd = 1'b1; dbg_addr = a;
        @(negedge clk);
        dbg_rd = 1'b0;
        d = dbg_rdata;
    endtask

    // Drive all buses with distinct values and strobe one instruction cycle.
    task automatic pulse_cycle(logic [15:0] p, logic [15:0] x, logic [15:0] y);
        @(negedge clk);
        pab = p; xab = x; yab = y; cyc_en = 1'b1;
        @(negedge clk);
        cyc_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 cmp_hit", {14'd0, cmp_hit}, 16'h0);
        chk("R1 bkpt_req", {15'd0, bkpt_req}, 16'h0);
        chk("R1 rdata", dbg_rdata, 16'h0);
        rd_reg(2'd0, v); chk("R1 limit0", v, 16'h0);
        rd_reg(2'd1, v); chk("R1 limit1", v, 16'h0);
        rd_reg(2'd2, v); chk("R1 ctrl", v, 16'h0);
        rd_reg(2'd3, v); chk("R1 latch", v, 16'h0);
    endtask

    task automatic t_bus_select();
        logic [15:0] v;
        wr_reg(2'd2, ctl(2'b01, 2'b00, 2'b00, 1'b0, 1'b0));
        pulse_cycle(16'h1111, 16'h2222, 16'h3333);
        rd_reg(2'd3, v); chk("R2 program bus", v, 16'h1111);
        wr_reg(2'd2, ctl(2'b10, 2'b00, 2'b00, 1'b0, 1'b0));
        pulse_cycle(16'h4444, 16'h5555, 16'h6666);
        rd_reg(2'd3, v); chk("R2 x bus", v, 16'h5555);
        wr_reg(2'd2, ctl(2'b11, 2'b00, 2'b00, 1'b0, 1'b0));
        pulse_cycle(16'h7777, 16'h8888, 16'h9999);
        rd_reg(2'd3, v); chk("R2 y bus", v, 16'h9999);
        wr_reg(2'd2, ctl(2'b00, 2'b00, 2'b00, 1'b0, 1'b0));
        pulse_cycle(16'hAAAA, 16'hBBBB, 16'hCCCC);
        rd_reg(2'd3, v); chk("R2 select none holds", v, 16'h9999);
    endtask

    task automatic t_hold();
        logic [15:0] v;
        wr_reg(2'd2, ctl(2'b01, 2'b00, 2'b00, 1'b0, 1'b0));
        @(negedge clk);
        pab = 16'hDEAD; xab = 16'hBEEF; yab = 16'hF00D;
        repeat (3) @(negedge clk);
        rd_reg(2'd3, v); chk("R3 latch holds without strobe", v, 16'h9999);
    endtask

    task automatic t_limits_rw();
        logic [15:0] v;
        wr_reg(2'd0, 16'hA5A5);
        wr_reg(2'd1, 16'h5A5A);
        rd_reg(2'd0, v); chk("R4 limit0 readback", v, 16'hA5A5);
        rd_reg(2'd1, v); chk("R4 limit1 readback", v, 16'h5A5A);
        // Latency: one clock after the read strobe
        @(negedge clk);
        dbg_rd = 1'b1; dbg_addr = 2'd0;
        chk("R4 rdata before edge", dbg_rdata, 16'h5A5A);
        @(negedge clk);
        dbg_rd = 1'b0;
        chk("R4 rdata after one edge", dbg_rdata, 16'hA5A5);
    endtask

    task automatic t_ctrl_readback();
        logic [15:0] v;
        wr_reg(2'd2, 16'h00D6);
        rd_reg(2'd2, v); chk("R5 ctrl readback", v, 16'h00D6);
        wr_reg(2'd2, 16'h0000);
        rd_reg(2'd3, v); chk("R5 latch register read", v, 16'h9999);
    endtask

    task automatic t_eq_ne();
        wr_reg(2'd0, 16'h1000);
        wr_reg(2'd1, 16'h1000);
        wr_reg(2'd2, ctl(2'b01, 2'b00, 2'b01, 1'b0, 1'b1));
        pulse_cycle(16'h1000, 16'h0000, 16'h0000);
        chk("R6 equal address", {14'd0, cmp_hit}, 16'h0001);
        pulse_cycle(16'h1001, 16'h1000, 16'h1000);
        chk("R6 unequal address", {14'd0, cmp_hit}, 16'h0002);
    endtask

    task automatic t_ge_lt();
        wr_reg(2'd0, 16'h2000);
        wr_reg(2'd1, 16'h3000);
        wr_reg(2'd2, ctl(2'b01, 2'b10, 2'b11, 1'b1, 1'b1));
        pulse_cycle(16'h1FFF, 16'h0, 16'h0);
        chk("R7 below lower", {14'd0, cmp_hit}, 16'h0002);
        @(negedge clk);
        chk("R8 AND with one hit", {15'd0, bkpt_req}, 16'h0);
        pulse_cycle(16'h2000, 16'h0, 16'h0);
        chk("R7 on lower", {14'd0, cmp_hit}, 16'h0003);
        chk("R10 req not yet", {15'd0, bkpt_req}, 16'h0);
        @(negedge clk);
        chk("R10 req one clock later", {15'd0, bkpt_req}, 16'h1);
        pulse_cycle(16'h2FFF, 16'h0, 16'h0);
        chk("R7 just below upper", {14'd0, cmp_hit}, 16'h0003);
        pulse_cycle(16'h3000, 16'h0, 16'h0);
        chk("R7 on upper", {14'd0, cmp_hit}, 16'h0001);
        chk("R10 req still from previous", {15'd0, bkpt_req}, 16'h1);
        @(negedge clk);
        chk("R8 AND drops", {15'd0, bkpt_req}, 16'h0);
        pulse_cycle(16'hFFFF, 16'h0, 16'h0);
        chk("R7 unsigned top", {14'd0, cmp_hit}, 16'h0001);
    endtask

    task automatic t_combine();
        wr_reg(2'd2, ctl(2'b01, 2'b10, 2'b11, 1'b0, 1'b1));
        @(negedge clk);
        chk("R8 OR with one hit", {15'd0, bkpt_req}, 16'h1);
        pulse_cycle(16'h0000, 16'h0, 16'h0);
        // lower GE fails at 0, upper LT holds: still one hit
        chk("R8 OR hits at zero", {14'd0, cmp_hit}, 16'h0002);
        wr_reg(2'd2, ctl(2'b01, 2'b00, 2'b00, 1'b0, 1'b1));
        @(negedge clk);
        chk("R8 OR with no hit", {15'd0, bkpt_req}, 16'h0);
    endtask

    task automatic t_disabled();
        wr_reg(2'd2, ctl(2'b01, 2'b10, 2'b11, 1'b1, 1'b0));
        pulse_cycle(16'h2800, 16'h0, 16'h0);
        chk("R9 no hit when disabled", {14'd0, cmp_hit}, 16'h0);
        @(negedge clk);
        chk("R9 no req when disabled", {15'd0, bkpt_req}, 16'h0);
        wr_reg(2'd2, ctl(2'b01, 2'b10, 2'b11, 1'b1, 1'b1));
        chk("R9 hits after enabling", {14'd0, cmp_hit}, 16'h0003);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bus_select();
        t_hold();
        t_limits_rw();
        t_ctrl_readback();
        t_eq_ne();
        t_ge_lt();
        t_combine();
        t_disabled();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule